// File: doc/BRIEF.md
# Program Counter and Return Stack

This block produces the instruction fetch address for a small core with 14-bit instruction words. It keeps an 11-bit program counter that moves forward one word on each executed step. Decoded strobes can replace that step. A long jump or long call loads an absolute target taken from the instruction word. A data write to the low address byte combines the ALU result with a separately latched upper part. A return takes the address from an eight-entry hardware return stack. An accepted interrupt saves the resume address and goes to the interrupt vector.

The surrounding core decodes instructions, runs the ALU and reads program memory. It drives one strobe per executed instruction and raises `step_en` whenever an instruction completes. `step_en` stays low while the core is stalled or asleep. The block returns the memory address and the low counter byte, which software reads as a register. It also returns a pulse that tells the interrupt controller to re-enable interrupts globally when a return-from-interrupt executes.

Top module: `pc_stack_unit`

## Requirements
- R1: A synchronous active-high `rst` forces the counter to 000H, empties the return stack (pointer to 0, every entry 000H) and clears the upper-address latch. This covers power-on, master-clear and watchdog resets.
- R2: When `step_en` is high and no strobe is active, the counter advances by one, wrapping from 7FFH to 000H. When `step_en` is low, the counter holds. The first step after a hold resumes at the held address plus one.
- R3: With `do_jump` or `do_call`, the counter loads `insn[10:0]`. Bits [13:11] are opcode bits decoded outside the block and are ignored here. If both strobes are set, the call is performed.
- R4: A call pushes the counter value plus one before it loads the target. A return (`do_ret`) pops the most recent entry into the counter, so nested calls return in last-in, first-out order.
- R5: `pcl_wr` loads the counter with `{latch[2:0], alu_res[7:0]}`. `hi_wr` stores `hi_din[2:0]` into the latch. A latch write in the same cycle as `pcl_wr` takes effect only for later writes.
- R6: `skip` advances the counter by two (modulo 2048).
- R7: `irq_take` pushes the current counter value, which is the address of the instruction that would have run, and loads 004H.
- R8: `gie_set` is high during a step that performs a return with `ret_rfi` high. It is low in every other cycle.
- R9: The stack pointer wraps modulo 8 without a flag. A ninth push overwrites the oldest entry. A pop from an empty stack returns whatever the entry below the pointer holds.
- R10: `fetch_addr` is counter bits [9:0]; bit 10 is dropped. `pcl_rd` is counter bits [7:0].
- R11: When several strobes are set, the priority is: interrupt, then return, then call or jump, then low-byte write, then skip, then plain increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | An instruction completes this cycle |
| irq_take | input | 1 | Interrupt accepted instead of the current instruction |
| do_ret | input | 1 | Return of any kind (plain, with literal, from interrupt) |
| ret_rfi | input | 1 | The return is a return-from-interrupt |
| do_call | input | 1 | Long call |
| do_jump | input | 1 | Long jump |
| pcl_wr | input | 1 | Data write of the low counter byte |
| skip | input | 1 | Skip condition met |
| insn | input | 14 | Current instruction word |
| alu_res | input | 8 | ALU result for low-byte writes |
| hi_wr | input | 1 | Write strobe of the upper-address latch |
| hi_din | input | 8 | Data for the upper-address latch |
| fetch_addr | output | 10 | Program memory address |
| pcl_rd | output | 8 | Low counter byte for reads |
| gie_set | output | 1 | Re-enable global interrupts |

## Verification
The bench builds the block with its default parameters: an 11-bit counter, a 10-bit memory address, an eight-deep stack and the vector at 004H. With an eight-deep stack, nine nested calls followed by ten returns can overwrite the oldest entry and then pop past empty in a short run. With the counter one bit wider than the memory address, a jump to a target with bit 10 set shows the dropped bit on `fetch_addr`. The same setting makes both 7FFH wraps (increment and skip) reachable.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    typedef enum logic [2:0] {
        NX_HOLD,
        NX_INC,
        NX_SKIP,
        NX_TARGET,
        NX_DATA,
        NX_POP,
        NX_VECTOR
    } nx_src_e;

    typedef struct packed {
        logic irq;
        logic ret;
        logic call;
        logic jump;
        logic pcl;
        logic skp;
    } strobe_t;

    typedef struct packed {
        logic push;
        logic pop;
    } stk_op_t;

    // Fixed priority: interrupt, return, call/jump, low-byte write, skip, increment
    function automatic nx_src_e pick_src(input logic step, input strobe_t s);
        nx_src_e r;
        if (!step)                 r = NX_HOLD;
        else if (s.irq)            r = NX_VECTOR;
        else if (s.ret)            r = NX_POP;
        else if (s.call || s.jump) r = NX_TARGET;
        else if (s.pcl)            r = NX_DATA;
        else if (s.skp)            r = NX_SKIP;
        else                       r = NX_INC;
        return r;
    endfunction

    function automatic stk_op_t stack_op(input nx_src_e src, input strobe_t s);
        stk_op_t o;
        o.push = (src == NX_VECTOR) || ((src == NX_TARGET) && s.call);
        o.pop  = (src == NX_POP);
        return o;
    endfunction

endpackage

// File: rtl/pcu_hi_latch.sv
module pcu_hi_latch #(
    parameter int HI_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [7:0]      din,
    output logic [HI_W-1:0] hi_q
);
    logic unused_hi;
    assign unused_hi = ^din[7:HI_W];

    always_ff @(posedge clk) begin
        if (rst)
            hi_q <= '0;
        else if (wr)
            hi_q <= din[HI_W-1:0];
    end
endmodule

// File: rtl/pcu_ret_stack.sv
module pcu_ret_stack #(
    parameter int W     = 11,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_val,
    output logic [W-1:0] top_val
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] ONE  = PTR_W'(1);

    logic [PTR_W-1:0] sp_q, sp_up, sp_dn;
    logic [W-1:0]     ent_q [DEPTH];

    assign sp_up   = (sp_q == LAST) ? '0 : sp_q + ONE;
    assign sp_dn   = (sp_q == '0) ? LAST : sp_q - ONE;
    assign top_val = ent_q[sp_dn];

    always_ff @(posedge clk) begin
        if (rst)
            sp_q <= '0;
        else if (push)
            sp_q <= sp_up;
        else if (pop)
            sp_q <= sp_dn;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                ent_q[i] <= '0;
            else if (push && (sp_q == PTR_W'(i)))
                ent_q[i] <= push_val;
        end
    end
endmodule

// File: rtl/pcu_next_sel.sv
module pcu_next_sel
    import pcu_pkg::*;
#(
    parameter int PC_W    = 11,
    parameter int HI_W    = 3,
    parameter int IRQ_VEC = 4
) (
    input  nx_src_e         src,
    input  logic [PC_W-1:0] pc_q,
    input  logic [PC_W-1:0] target,
    input  logic [7:0]      alu_res,
    input  logic [HI_W-1:0] hi_q,
    input  logic [PC_W-1:0] pop_val,
    output logic [PC_W-1:0] pc_nxt,
    output logic [PC_W-1:0] push_val
);
    localparam logic [PC_W-1:0] ONE = PC_W'(1);
    localparam logic [PC_W-1:0] TWO = PC_W'(2);
    localparam logic [PC_W-1:0] VEC = PC_W'(IRQ_VEC);

    logic [PC_W-1:0] pc_inc;
    assign pc_inc   = pc_q + ONE;
    assign push_val = (src == NX_VECTOR) ? pc_q : pc_inc;

    always_comb begin
        unique case (src)
            NX_INC:    pc_nxt = pc_inc;
            NX_SKIP:   pc_nxt = pc_q + TWO;
            NX_TARGET: pc_nxt = target;
            NX_DATA:   pc_nxt = {hi_q, alu_res};
            NX_POP:    pc_nxt = pop_val;
            NX_VECTOR: pc_nxt = VEC;
            default:   pc_nxt = pc_q;
        endcase
    end
endmodule

// File: rtl/pc_stack_unit.sv
module pc_stack_unit
    import pcu_pkg::*;
#(
    parameter int PC_W      = 11,
    parameter int MEM_AW    = 10,
    parameter int INSN_W    = 14,
    parameter int STK_DEPTH = 8,
    parameter int IRQ_VEC   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_en,
    input  logic              irq_take,
    input  logic              do_ret,
    input  logic              ret_rfi,
    input  logic              do_call,
    input  logic              do_jump,
    input  logic              pcl_wr,
    input  logic              skip,
    input  logic [INSN_W-1:0] insn,
    input  logic [7:0]        alu_res,
    input  logic              hi_wr,
    input  logic [7:0]        hi_din,
    output logic [MEM_AW-1:0] fetch_addr,
    output logic [7:0]        pcl_rd,
    output logic              gie_set
);
    localparam int HI_W = PC_W - 8;

    logic [PC_W-1:0] pc_q, pc_nxt, push_val, pop_val;
    logic [HI_W-1:0] hi_q;
    strobe_t         stb;
    nx_src_e         src;
    stk_op_t         sop;
    logic            unused_insn;

    assign unused_insn = ^insn[INSN_W-1:PC_W];

    assign stb = '{irq: irq_take, ret: do_ret, call: do_call,
                   jump: do_jump, pcl: pcl_wr, skp: skip};
    assign src = pick_src(step_en, stb);
    assign sop = stack_op(src, stb);

    pcu_hi_latch #(.HI_W(HI_W)) u_hi (
        .clk (clk),
        .rst (rst),
        .wr  (hi_wr),
        .din (hi_din),
        .hi_q(hi_q)
    );

    pcu_ret_stack #(.W(PC_W), .DEPTH(STK_DEPTH)) u_stk (
        .clk     (clk),
        .rst     (rst),
        .push    (sop.push),
        .pop     (sop.pop),
        .push_val(push_val),
        .top_val (pop_val)
    );

    pcu_next_sel #(.PC_W(PC_W), .HI_W(HI_W), .IRQ_VEC(IRQ_VEC)) u_sel (
        .src     (src),
        .pc_q    (pc_q),
        .target  (insn[PC_W-1:0]),
        .alu_res (alu_res),
        .hi_q    (hi_q),
        .pop_val (pop_val),
        .pc_nxt  (pc_nxt),
        .push_val(push_val)
    );

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= '0;
        else
            pc_q <= pc_nxt;
    end

    assign fetch_addr = pc_q[MEM_AW-1:0];
    assign pcl_rd     = pc_q[7:0];
    assign gie_set    = sop.pop && ret_rfi;
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
    parameter int PC_W    = 11,
    parameter int INSN_W  = 14,
    parameter int IRQ_VEC = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              step_en,
    input logic              irq_take,
    input logic              do_ret,
    input logic              do_call,
    input logic              do_jump,
    input logic              pcl_wr,
    input logic              skip,
    input logic [INSN_W-1:0] insn,
    input logic              gie_set,
    input logic [PC_W-1:0]   pc
);
    localparam logic [PC_W-1:0] ONE = PC_W'(1);
    localparam logic [PC_W-1:0] TWO = PC_W'(2);
    localparam logic [PC_W-1:0] VEC = PC_W'(IRQ_VEC);

    logic plain;
    assign plain = !irq_take && !do_ret && !do_call && !do_jump && !pcl_wr && !skip;

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> pc == '0); // R1
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(pc)); // R2
    AST_INC_ONE: assert property (@(posedge clk) disable iff (rst)
        step_en && plain |=> pc == $past(pc) + ONE); // R2
    AST_TARGET_LOAD: assert property (@(posedge clk) disable iff (rst)
        step_en && !irq_take && !do_ret && (do_call || do_jump)
        |=> pc == $past(insn[PC_W-1:0])); // R3
    AST_SKIP_TWO: assert property (@(posedge clk) disable iff (rst)
        step_en && skip && !irq_take && !do_ret && !do_call && !do_jump && !pcl_wr
        |=> pc == $past(pc) + TWO); // R6
    AST_VECTOR_LOAD: assert property (@(posedge clk) disable iff (rst)
        step_en && irq_take |=> pc == VEC); // R7
    AST_GIE_ON_RETURN: assert property (@(posedge clk) disable iff (rst)
        gie_set |-> step_en && do_ret && !irq_take); // R8
endmodule

bind pc_stack_unit pcu_checker #(.PC_W(PC_W), .INSN_W(INSN_W), .IRQ_VEC(IRQ_VEC)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_en),
    .irq_take(irq_take),
    .do_ret  (do_ret),
    .do_call (do_call),
    .do_jump (do_jump),
    .pcl_wr  (pcl_wr),
    .skip    (skip),
    .insn    (insn),
    .gie_set (gie_set),
    .pc      (pc_q)
);

// File: tb/sim_pc_stack_unit.sv
module sim_pc_stack_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_en = 0, irq_take = 0, do_ret = 0, ret_rfi = 0;
    logic        do_call = 0, do_jump = 0, pcl_wr = 0, skip = 0, hi_wr = 0;
    logic [13:0] insn = '0;
    logic [7:0]  alu_res = '0, hi_din = '0;
    logic [9:0]  fetch_addr;
    logic [7:0]  pcl_rd;
    logic        gie_set;

    int n_run = 0, n_fail = 0;
    bit done = 0;
    int m_pc, m_sp, m_hi;
    int m_stk [8];

    always #4 clk = ~clk;

    pc_stack_unit u0 (
        .clk(clk), .rst(rst), .step_en(step_en), .irq_take(irq_take),
        .do_ret(do_ret), .ret_rfi(ret_rfi), .do_call(do_call), .do_jump(do_jump),
        .pcl_wr(pcl_wr), .skip(skip), .insn(insn), .alu_res(alu_res),
        .hi_wr(hi_wr), .hi_din(hi_din), .fetch_addr(fetch_addr),
        .pcl_rd(pcl_rd), .gie_set(gie_set)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic m_push(input int v);
        m_stk[m_sp] = v;
        m_sp = (m_sp + 1) % 8;
    endtask

    task automatic m_reset();
        m_pc = 0; m_sp = 0; m_hi = 0;
        foreach (m_stk[i]) m_stk[i] = 0;
    endtask

    task automatic cmp_out(input string tag);
        chk(fetch_addr == 10'(m_pc % 1024), tag, fetch_addr, m_pc % 1024);
        chk(pcl_rd == 8'(m_pc % 256), tag, pcl_rd, m_pc % 256);
    endtask

    // Called at a falling edge; drives one cycle, checks outputs at the next falling edge
    task automatic cyc(input bit en, input bit irq, input bit ret, input bit rfi,
                       input bit call, input bit jmp, input bit pw, input bit skp,
                       input int ins, input int alu, input bit hw, input int hd,
                       input string tag);
        int nx;
        step_en = en; irq_take = irq; do_ret = ret; ret_rfi = rfi;
        do_call = call; do_jump = jmp; pcl_wr = pw; skip = skp;
        insn = 14'(ins); alu_res = 8'(alu); hi_wr = hw; hi_din = 8'(hd);
        #1;
        chk(gie_set == (en && !irq && ret && rfi), "R8", gie_set, en && !irq && ret && rfi);
        nx = m_pc;
        if (en) begin
            if (irq) begin m_push(m_pc); nx = 4; end
            else if (ret) begin m_sp = (m_sp + 7) % 8; nx = m_stk[m_sp]; end
            else if (call) begin m_push((m_pc + 1) % 2048); nx = ins % 2048; end
            else if (jmp) nx = ins % 2048;
            else if (pw) nx = m_hi * 256 + (alu % 256);
            else if (skp) nx = (m_pc + 2) % 2048;
            else nx = (m_pc + 1) % 2048;
        end
        if (hw) m_hi = hd % 8;
        m_pc = nx;
        @(negedge clk);
        cmp_out(tag);
    endtask

    task automatic inc(input string tag);
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step_en = 0; irq_take = 0; do_ret = 0; ret_rfi = 0; do_call = 0;
        do_jump = 0; pcl_wr = 0; skip = 0; hi_wr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_reset();
        cmp_out("R1");
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        m_reset();
        @(negedge clk);
        do_reset();
        // R2: plain increments, then a hold and resume
        for (int i = 0; i < 5; i++) inc("R2");
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        inc("R2");
        // R3/R10: jump with opcode bits and bit 10 set, then wrap past 7FFH
        cyc(1, 0, 0, 0, 0, 1, 0, 0, 14'h2FFE, 0, 0, 0, "R3");
        chk(fetch_addr == 10'h3FE, "R10", fetch_addr, 10'h3FE);
        inc("R2"); inc("R2");
        chk(fetch_addr == 10'h000, "R2", fetch_addr, 0);
        // R6: skip, including across the top of the range
        cyc(1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R6");
        cyc(1, 0, 0, 0, 0, 1, 0, 0, 14'h07FF, 0, 0, 0, "R3");
        cyc(1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R6");
        // R5: latch then low-byte writes; same-cycle latch write uses old value
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'hFD, "R5");
        cyc(1, 0, 0, 0, 0, 0, 1, 0, 0, 8'h3C, 0, 0, "R5");
        chk(pcl_rd == 8'h3C, "R5", pcl_rd, 8'h3C);
        cyc(1, 0, 0, 0, 0, 0, 1, 0, 0, 8'h10, 1, 2, "R5");
        cyc(1, 0, 0, 0, 0, 0, 1, 0, 0, 8'h20, 0, 0, "R5");
        // R4: nested calls and returns
        cyc(1, 0, 0, 0, 1, 0, 0, 0, 14'h2100, 0, 0, 0, "R4");
        inc("R4");
        cyc(1, 0, 0, 0, 1, 1, 0, 0, 14'h0300, 0, 0, 0, "R3");
        cyc(1, 0, 0, 0, 1, 0, 0, 0, 14'h0455, 0, 0, 0, "R4");
        for (int i = 0; i < 3; i++) cyc(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
        // R7/R8: interrupt vector and return from interrupt
        inc("R7");
        cyc(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
        chk(fetch_addr == 10'h004, "R7", fetch_addr, 4);
        inc("R7");
        cyc(1, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
        cyc(0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
        // R11: priority with several strobes
        cyc(1, 1, 1, 1, 1, 1, 1, 1, 14'h0123, 8'h55, 0, 0, "R11");
        cyc(1, 0, 1, 0, 1, 1, 1, 1, 14'h0123, 8'h55, 0, 0, "R11");
        cyc(1, 0, 0, 0, 0, 1, 1, 1, 14'h0321, 8'h55, 0, 0, "R11");
        cyc(1, 0, 0, 0, 0, 0, 1, 1, 0, 8'h77, 0, 0, "R11");
        // R9: nine calls overwrite oldest, ten returns pop past empty
        for (int i = 0; i < 9; i++) cyc(1, 0, 0, 0, 1, 0, 0, 0, 16 * i + 8, 0, 0, 0, "R9");
        for (int i = 0; i < 10; i++) cyc(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
        // R1: mid-run reset clears latch, counter and stack
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 7, "R1");
        do_reset();
        cyc(1, 0, 0, 0, 0, 0, 1, 0, 0, 8'h33, 0, 0, "R1");
        chk(fetch_addr == 10'h033, "R1", fetch_addr, 10'h033);
        cyc(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
        chk(fetch_addr == 10'h000, "R1", fetch_addr, 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule